// File: doc/BRIEF.md
# PCI Target Prefetching Read Controller

This block is the read engine on the PCI target side of a bus bridge. When a PCI master starts a memory read, the block works out from the command type and two configuration inputs how many bytes to fetch from the far-side bus. It records the address and command of that first attempt and sends one request over an internal valid/ready channel. It then terminates the master with retry until every requested word has arrived on the data-return channel and sits in a local read buffer.

A later attempt with the same address and command is accepted. After that, each data phase the master requests returns one buffered 32-bit word, in the order the words arrived. On the last prefetched word the block signals a disconnect, so the master never receives data from beyond the fetched range. If the master ends the burst early, the remaining words are dropped and the block returns to idle. The PCI bus itself is abstracted into one-cycle attempt, phase and end strobes.

Top module: `pt_rd_ctrl`

## Requirements
- R1: After synchronous reset, `pci_retry`, `pci_ack`, `pci_dvalid`, `pci_disc` and `rq_valid` are all low.
- R2: A plain memory read (command 4'b0110) requests 4 bytes when `cfg_promote` is 0 and 32 bytes when it is 1.
- R3: A memory read line (command 4'b1110) requests 32 bytes whatever `cfg_mult_sel` holds.
- R4: A memory read multiple (command 4'b1100) requests 64, 128, 256 or 512 bytes for `cfg_mult_sel` equal to 0, 1, 2 or 3.
- R5: An accepted idle attempt raises `rq_valid` one cycle later, with `rq_addr` equal to the attempt address. `rq_valid`, `rq_addr` and `rq_bytes` hold steady until the cycle in which `rq_ready` is high, and then `rq_valid` drops. Exactly one request is made for each delayed read.
- R6: Every read attempt made before the buffer holds all requested words is answered with `pci_retry` one cycle later, and no `pci_ack` is given. This includes an attempt in the same cycle as the final word.
- R7: Once the buffer is full, an attempt whose address or command differs from the latched ones gets `pci_retry` and starts no new request.
- R8: Once the buffer is full, an attempt that matches the latched address and command gets `pci_ack` one cycle later and no `pci_retry`.
- R9: After `pci_ack`, each cycle with `pci_phase` high (and `pci_end` low) gives `pci_dvalid` one cycle later. `pci_data` carries the buffered words in arrival order.
- R10: The word for the last prefetched position comes with `pci_disc` high. Later phases produce no `pci_dvalid`.
- R11: `pci_end` during data return discards the remaining words and returns the block to idle. The next read attempt then issues a fresh request.
- R12: An attempt with any other command code gets no `pci_retry`, no `pci_ack` and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promote | input | 1 | Promote a plain memory read to a 32-byte fetch |
| cfg_mult_sel | input | 2 | Size select for read multiple |
| att_valid | input | 1 | A master attempt starts this cycle |
| att_addr | input | ADDR_W | Attempt address |
| att_cmd | input | 4 | Attempt command code |
| pci_phase | input | 1 | Master requests a data phase |
| pci_end | input | 1 | Master ends the burst |
| pci_retry | output | 1 | Terminate the attempt with retry |
| pci_ack | output | 1 | Attempt accepted, data return begins |
| pci_dvalid | output | 1 | `pci_data` holds a valid word |
| pci_data | output | DATA_W | Returned word |
| pci_disc | output | 1 | Disconnect: this is the last word |
| rq_valid | output | 1 | Far-side request valid |
| rq_ready | input | 1 | Far-side request accepted |
| rq_addr | output | ADDR_W | Request address |
| rq_bytes | output | clog2(BUF_BYTES)+1 | Request length in bytes |
| rd_valid | input | 1 | Returned data word valid |
| rd_data | input | DATA_W | Returned data word |
| rd_last | input | 1 | Final returned word of the request |

## Verification
The bench builds the block with its default parameters: 32-bit words and a 512-byte buffer of 128 entries. These defaults reach every request size, from the 4-byte single beat through the full 512-byte fetch at select 3, where the buffer fills exactly to capacity. They also reach the disconnect on the last buffer entry and phases pushed past it. At this depth, attempts made during the request, during the fill and in the same cycle as the final word are all exercised within a short run.

// File: rtl/pt_rd_pkg.sv
package pt_rd_pkg;
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_FULL,
    ST_XFER
  } rd_state_e;
endpackage

// File: rtl/pt_rd_size.sv
module pt_rd_size
  import pt_rd_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 32,
  parameter int MULT_BASE  = 64
) (
  input  logic [3:0]       cmd,
  input  logic             promote,
  input  logic [1:0]       mult_sel,
  output logic             is_read,
  output logic [LEN_W-1:0] bytes
);
  always_comb begin
    is_read = 1'b1;
    bytes   = LEN_W'(WORD_BYTES);
    case (cmd)
      CMD_MEM_RD:      bytes = promote ? LEN_W'(LINE_BYTES) : LEN_W'(WORD_BYTES);
      CMD_MEM_RD_LINE: bytes = LEN_W'(LINE_BYTES);
      CMD_MEM_RD_MULT: bytes = LEN_W'(MULT_BASE) << mult_sel;
      default:         is_read = 1'b0;
    endcase
  end
endmodule

// File: rtl/pt_rd_buf.sv
module pt_rd_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pt_rd_ctrl.sv
module pt_rd_ctrl
  import pt_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_promote,
  input  logic [1:0]                 cfg_mult_sel,
  input  logic                       att_valid,
  input  logic [ADDR_W-1:0]          att_addr,
  input  logic [3:0]                 att_cmd,
  input  logic                       pci_phase,
  input  logic                       pci_end,
  output logic                       pci_retry,
  output logic                       pci_ack,
  output logic                       pci_dvalid,
  output logic [DATA_W-1:0]          pci_data,
  output logic                       pci_disc,
  output logic                       rq_valid,
  input  logic                       rq_ready,
  output logic [ADDR_W-1:0]          rq_addr,
  output logic [$clog2(BUF_BYTES):0] rq_bytes,
  input  logic                       rd_valid,
  input  logic [DATA_W-1:0]          rd_data,
  input  logic                       rd_last
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WB_SH      = $clog2(WORD_BYTES);
  localparam int LEN_W      = $clog2(BUF_BYTES) + 1;
  localparam int DEPTH      = BUF_BYTES / WORD_BYTES;
  localparam int PTR_W      = $clog2(DEPTH);
  localparam int CNT_W      = PTR_W + 1;

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;
  logic [CNT_W-1:0]  need_q, wcnt_q, rptr_q;

  logic             dec_read;
  logic [LEN_W-1:0] dec_bytes;
  logic [CNT_W-1:0] dec_words;
  logic             att_ok, att_match, buf_wr, buf_rd;

  pt_rd_size #(
    .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES), .LINE_BYTES(32), .MULT_BASE(64)
  ) u_size (
    .cmd(att_cmd), .promote(cfg_promote), .mult_sel(cfg_mult_sel),
    .is_read(dec_read), .bytes(dec_bytes)
  );

  assign dec_words = CNT_W'(dec_bytes >> WB_SH);
  assign att_ok    = att_valid && dec_read;
  assign att_match = (att_addr == addr_q) && (att_cmd == cmd_q);
  assign buf_wr    = (state_q == ST_FILL) && rd_valid;
  assign buf_rd    = (state_q == ST_XFER) && pci_phase && !pci_end;

  pt_rd_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk),
    .wr_en(buf_wr), .wr_addr(wcnt_q[PTR_W-1:0]), .wr_data(rd_data),
    .rd_en(buf_rd), .rd_addr(rptr_q[PTR_W-1:0]), .rd_data(pci_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      cmd_q      <= '0;
      need_q     <= '0;
      wcnt_q     <= '0;
      rptr_q     <= '0;
      pci_retry  <= 1'b0;
      pci_ack    <= 1'b0;
      pci_dvalid <= 1'b0;
      pci_disc   <= 1'b0;
      rq_valid   <= 1'b0;
      rq_addr    <= '0;
      rq_bytes   <= '0;
    end else begin
      pci_retry  <= 1'b0;
      pci_ack    <= 1'b0;
      pci_dvalid <= 1'b0;
      pci_disc   <= 1'b0;
      case (state_q)
        ST_IDLE: if (att_ok) begin
          addr_q    <= att_addr;
          cmd_q     <= att_cmd;
          need_q    <= dec_words;
          wcnt_q    <= '0;
          rq_valid  <= 1'b1;
          rq_addr   <= att_addr;
          rq_bytes  <= dec_bytes;
          pci_retry <= 1'b1;
          state_q   <= ST_REQ;
        end
        ST_REQ: begin
          if (att_ok) pci_retry <= 1'b1;
          if (rq_ready) begin
            rq_valid <= 1'b0;
            state_q  <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (att_ok) pci_retry <= 1'b1;
          if (rd_valid) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q + 1'b1 == need_q) state_q <= ST_FULL;
          end
        end
        ST_FULL: if (att_ok) begin
          if (att_match) begin
            pci_ack <= 1'b1;
            rptr_q  <= '0;
            state_q <= ST_XFER;
          end else begin
            pci_retry <= 1'b1;
          end
        end
        ST_XFER: begin
          if (pci_end) begin
            state_q <= ST_IDLE;
          end else if (pci_phase) begin
            pci_dvalid <= 1'b1;
            rptr_q     <= rptr_q + 1'b1;
            if (rptr_q == need_q - 1'b1) begin
              pci_disc <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr) && $stable(rq_bytes));

  assert_req_size_legal_R4: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> $countones(rq_bytes) == 1);

  assert_no_early_ack_R6: assert property (@(posedge clk) disable iff (rst)
    pci_ack |-> $past(wcnt_q) == $past(need_q));

  assert_retry_ack_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(pci_retry && pci_ack));

  assert_no_overfill_R9: assert property (@(posedge clk) disable iff (rst)
    buf_wr |-> wcnt_q < need_q);

  assert_last_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    buf_wr && rd_last |-> wcnt_q + 1'b1 == need_q);

  assert_no_overread_R10: assert property (@(posedge clk) disable iff (rst)
    pci_dvalid |-> $past(rptr_q) < $past(need_q));
endmodule

// File: tb/pt_rd_ctrl_tb.sv
`timescale 1ns/1ps
module pt_rd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_promote = 0;
  logic [1:0]  cfg_mult_sel = 0;
  logic        att_valid = 0;
  logic [31:0] att_addr = 0;
  logic [3:0]  att_cmd = 0;
  logic        pci_phase = 0, pci_end = 0;
  logic        pci_retry, pci_ack, pci_dvalid, pci_disc;
  logic [31:0] pci_data;
  logic        rq_valid;
  logic        rq_ready = 0;
  logic [31:0] rq_addr;
  logic [9:0]  rq_bytes;
  logic        rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic        rd_last = 0;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  pt_rd_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_promote(cfg_promote), .cfg_mult_sel(cfg_mult_sel),
    .att_valid(att_valid), .att_addr(att_addr), .att_cmd(att_cmd),
    .pci_phase(pci_phase), .pci_end(pci_end),
    .pci_retry(pci_retry), .pci_ack(pci_ack), .pci_dvalid(pci_dvalid),
    .pci_data(pci_data), .pci_disc(pci_disc),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_bytes(rq_bytes),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  function automatic int exp_bytes(logic [3:0] c, bit p, logic [1:0] s);
    case (c)
      4'b0110: return p ? 32 : 4;
      4'b1110: return 32;
      4'b1100: return 64 << s;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int          m_st = 0, m_need = 0, m_rp = 0;
  logic [31:0] m_la;
  logic [3:0]  m_lc;
  logic [31:0] m_buf[$];
  logic        e_retry = 0, e_ack = 0, e_dv = 0, e_disc = 0, e_rqv = 0;
  logic [31:0] e_data = 0, e_rqa = 0;
  int          e_rqb = 0;
  bit          armed = 0;

  always @(posedge clk) begin
    bit ok;
    armed = 1;
    ok = att_valid && exp_bytes(att_cmd, cfg_promote, cfg_mult_sel) != 0;
    if (rst) begin
      m_st = 0; e_retry = 0; e_ack = 0; e_dv = 0; e_disc = 0; e_rqv = 0;
      e_rqa = 0; e_rqb = 0;
    end else begin
      e_retry = 0; e_ack = 0; e_dv = 0; e_disc = 0;
      case (m_st)
        0: if (ok) begin
          m_la = att_addr; m_lc = att_cmd;
          e_rqb = exp_bytes(att_cmd, cfg_promote, cfg_mult_sel);
          m_need = e_rqb / 4; e_rqv = 1; e_rqa = att_addr;
          m_buf.delete(); e_retry = 1; m_st = 1;
        end
        1: begin
          if (ok) e_retry = 1;
          if (rq_ready) begin e_rqv = 0; m_st = 2; end
        end
        2: begin
          if (ok) e_retry = 1;
          if (rd_valid) begin
            m_buf.push_back(rd_data);
            if (m_buf.size() == m_need) m_st = 3;
          end
        end
        3: if (ok) begin
          if (att_addr == m_la && att_cmd == m_lc) begin e_ack = 1; m_rp = 0; m_st = 4; end
          else e_retry = 1;
        end
        default: begin
          if (pci_end) m_st = 0;
          else if (pci_phase) begin
            e_dv = 1; e_data = m_buf[m_rp]; m_rp++;
            if (m_rp == m_need) begin e_disc = 1; m_st = 0; end
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk("R6 retry model", 32'(pci_retry), 32'(e_retry));
      chk("R8 ack model", 32'(pci_ack), 32'(e_ack));
      chk("R9 dvalid model", 32'(pci_dvalid), 32'(e_dv));
      chk("R10 disc model", 32'(pci_disc), 32'(e_disc));
      chk("R5 rq_valid model", 32'(rq_valid), 32'(e_rqv));
      if (e_rqv) begin
        chk("R5 rq_addr model", rq_addr, e_rqa);
        chk("R5 rq_bytes model", 32'(rq_bytes), 32'(e_rqb));
      end
      if (e_dv) chk("R9 data model", pci_data, e_data);
    end
  end

  task automatic attempt(logic [3:0] c, logic [31:0] a);
    att_valid = 1; att_cmd = c; att_addr = a;
    @(negedge clk);
    att_valid = 0;
  endtask

  task automatic run_read(string tag, logic [3:0] c, logic [31:0] a, bit p,
                          logic [1:0] s, int end_after, int extra);
    int nb, nw;
    cfg_promote = p; cfg_mult_sel = s;
    nb = exp_bytes(c, p, s); nw = nb / 4;
    attempt(c, a);
    chk({tag, " request size"}, 32'(rq_bytes), 32'(nb));
    chk({tag, " request valid"}, 32'(rq_valid), 1);
    chk("R6 first retry", 32'(pci_retry), 1);
    attempt(c, a ^ 32'h100);
    chk("R6 retry during request", 32'(pci_retry), 1);
    chk("R5 address held", rq_addr, a);
    @(negedge clk);
    rq_ready = 1;
    @(negedge clk);
    rq_ready = 0;
    chk("R5 valid dropped", 32'(rq_valid), 0);
    for (int i = 0; i < nw; i++) begin
      rd_valid = 1; rd_data = {a[15:0], 16'(i * 7 + 3)}; rd_last = (i == nw - 1);
      att_valid = (i == nw / 2); att_cmd = c; att_addr = a;
      @(negedge clk);
      rd_valid = 0; rd_last = 0;
      if (att_valid) chk("R6 retry during fill", 32'(pci_retry), 1);
      att_valid = 0;
      if (i % 3 == 1) @(negedge clk);
    end
    attempt(c, a + 32'h40);
    chk("R7 mismatch retried", 32'(pci_retry), 1);
    chk("R7 no new request", 32'(rq_valid), 0);
    attempt(c, a);
    chk("R8 match acked", 32'(pci_ack), 1);
    chk("R8 no retry", 32'(pci_retry), 0);
    for (int i = 0; i < nw + extra; i++) begin
      if (i == end_after) begin
        pci_end = 1;
        @(negedge clk);
        pci_end = 0;
        chk("R11 no data at end", 32'(pci_dvalid), 0);
        break;
      end
      pci_phase = 1;
      @(negedge clk);
      pci_phase = 0;
      if (i < nw) begin
        chk("R9 word valid", 32'(pci_dvalid), 1);
        chk("R9 word order", pci_data, {a[15:0], 16'(i * 7 + 3)});
        chk("R10 disconnect flag", 32'(pci_disc), 32'(i == nw - 1));
      end else begin
        chk("R10 nothing past end", 32'(pci_dvalid), 0);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 retry low", 32'(pci_retry), 0);
    chk("R1 ack low", 32'(pci_ack), 0);
    chk("R1 dvalid low", 32'(pci_dvalid), 0);
    chk("R1 disc low", 32'(pci_disc), 0);
    chk("R1 rq_valid low", 32'(rq_valid), 0);
    attempt(4'b0010, 32'h1000);
    chk("R12 ignored retry", 32'(pci_retry), 0);
    chk("R12 ignored request", 32'(rq_valid), 0);
    @(negedge clk);
    chk("R12 ignored ack", 32'(pci_ack), 0);
    run_read("R2", 4'b0110, 32'h0000_2000, 0, 2'd2, -1, 2);
    run_read("R2", 4'b0110, 32'h0000_3000, 1, 2'd0, -1, 1);
    run_read("R3", 4'b1110, 32'h0000_4000, 0, 2'd3, -1, 1);
    for (int s = 0; s < 4; s++)
      run_read("R4", 4'b1100, 32'h0001_0000 + 32'(s) * 32'h1000, 0, 2'(s), -1, 1);
    run_read("R4", 4'b1100, 32'h0002_0000, 0, 2'd1, 5, 0);
    run_read("R11", 4'b1100, 32'h0002_0000, 0, 2'd1, -1, 1);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule